// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a synthesizable model of a small synchronous static memory. The array holds words split into byte lanes; by default there are two 9-bit lanes, so each word is 18 bits. On every rising clock edge the control inputs are decoded into one of three kinds of cycle. A deselect ends any burst. A begin-burst cycle loads an address from the address pins. A continue cycle works on the burst address already held: it either steps that address or keeps it. Read data is not registered a second time. The word at the registered address shows on the read port in the same cycle that follows the edge. The output enable acts at once and is not sampled by the clock.

The block has two address strobes. The processor-side strobe always begins a read. The controller-side strobe begins a burst that writes at once if the write controls ask for it. Writes also happen on continue cycles. A sleep request stops the block from acting on its inputs. While it is held, the read port is not driven, any burst in progress ends, and the stored contents are kept. Sleep is entered in two clock edges. After the request is dropped, two more edges pass before normal operation returns.

Top module: `ft_burst_sram`

## Requirements
- R1: When the processor strobe is low with the first enable active, the edge begins a read burst at the address on the pins. No lane is written at that edge, whatever the write controls show.
- R2: When the controller strobe is low and the processor strobe does not apply, with all three enables active, the edge loads the pin address. It writes that address at the same edge if the write decode selects any lane; otherwise it begins a read burst.
- R3: Lane write decode works as follows. If the global write is low, every lane is written. If the global write is high and the lane-write enable is low, a lane is written when its bit in the lane select is low (bit 0 selects bits 8:0, bit 1 selects bits 17:9). If both the global write and the lane-write enable are high, no lane is written.
- R4: A strobe that applies while any enable is inactive is a deselect: the read port is not driven until a later begin. A processor strobe given while the first enable is high has no effect.
- R5: On an edge with no strobe, a burst in progress and the step input low, the burst address moves to the next word. The two low address bits count up by one and wrap from 3 to 0, and the upper bits stay the same. Reads and writes use the new address.
- R6: On an edge with no strobe, a burst in progress and the step input high, the burst keeps the current address for that cycle's read or write.
- R7: After a read edge, the read port shows the word at the registered address in that same cycle. The drive flag follows the output enable without waiting for a clock edge.
- R8: The drive flag is low for the whole cycle after any edge that wrote, whatever the output enable shows.
- R9: While the sleep request is high, edges ignore every other input, nothing is written, the drive flag is low and any burst ends. The stored words are kept.
- R10: After the sleep request falls, the first two edges still ignore the inputs. The third edge behaves normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_a_n | input | 1 | First chip enable, active low; also qualifies the processor strobe |
| en_b | input | 1 | Second chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low; always begins a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low; may begin a write |
| step_n | input | 1 | Burst step, active low; high suspends the burst address |
| addr | input | ADDR_W | Word address loaded at a begin cycle |
| wr_all_n | input | 1 | Global write, active low; writes all lanes |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| wdata | input | LANE_W*LANES | Write data sampled at the write edge |
| rdata | output | LANE_W*LANES | Word at the registered burst address |
| rdata_drive | output | 1 | High when the read port would drive the shared data bus |

## Verification
The assertions assume the strobes, enables, step and write controls are stable around each rising edge. They also assume the sleep request is driven to a known level at every edge, since it both gates the drive flag at once and feeds the sleep sequencer. The stimulus changes every input only on the falling clock edge. The one exception is a single mid-cycle toggle of the output enable, which checks that it acts without a clock. Every burst read targets words written earlier in the same run, so no comparison depends on the array's power-up contents.

// File: rtl/ft_sram_pkg.sv
`timescale 1ns/1ps
package ft_sram_pkg;

  // Sleep sequencer states
  typedef enum logic [1:0] {
    SLP_RUN   = 2'd0,
    SLP_ENTER = 2'd1,
    SLP_DOWN  = 2'd2,
    SLP_WAKE  = 2'd3
  } slp_state_e;

endpackage

// File: rtl/ft_sram_sleep.sv
`timescale 1ns/1ps
module ft_sram_sleep
  import ft_sram_pkg::*;
#(
  parameter int SLEEP_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic quiet
);

  localparam int MAX_CYC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(SLEEP_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SLP_RUN: begin
        if (sleep_req) begin
          state_d = SLP_ENTER;
          cnt_d   = CNT_ONE;
        end
      end
      SLP_ENTER: begin
        if (!sleep_req) begin
          state_d = SLP_WAKE;
          cnt_d   = CNT_ONE;
        end else if (cnt_q >= ENTER_LAST) begin
          state_d = SLP_DOWN;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      SLP_DOWN: begin
        if (!sleep_req) begin
          state_d = SLP_WAKE;
          cnt_d   = CNT_ONE;
        end
      end
      SLP_WAKE: begin
        if (sleep_req) begin
          state_d = SLP_ENTER;
          cnt_d   = CNT_ONE;
        end else if (cnt_q >= WAKE_LAST) begin
          state_d = SLP_RUN;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: begin
        state_d = SLP_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLP_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Inputs are ignored while the request is high and until the sequencer is back in RUN.
  assign quiet = sleep_req || (state_q != SLP_RUN);

  assert_wake_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLP_DOWN && !sleep_req) |=> quiet);

  assert_enter_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLP_RUN && sleep_req) |=> (state_q == SLP_ENTER));

endmodule

// File: rtl/ft_sram_decode.sv
`timescale 1ns/1ps
module ft_sram_decode #(
  parameter int LANES = 2
) (
  input  logic             quiet,
  input  logic             active_q,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic             load_ext,
  output logic             step,
  output logic             deselect,
  output logic             proc_begin,
  output logic [LANES-1:0] wr_lanes
);

  logic             cpu_hit;
  logic             ctl_hit;
  logic             start;
  logic             enabled;
  logic             cont;
  logic [LANES-1:0] lanes_req;

  always_comb begin
    // The processor strobe only counts when the first enable is active.
    cpu_hit  = !quiet && !strb_cpu_n && !en_a_n;
    ctl_hit  = !quiet && !strb_ctl_n;
    start    = cpu_hit || ctl_hit;
    enabled  = !en_a_n && en_b && !en_c_n;
    deselect = start && !enabled;
    load_ext = start && enabled;
    proc_begin = load_ext && cpu_hit;
    cont     = !quiet && !start && active_q;
    step     = cont && !step_n;
  end

  always_comb begin
    if (!wr_all_n) begin
      lanes_req = '1;
    end else if (!wr_lane_en_n) begin
      lanes_req = ~lane_sel_n;
    end else begin
      lanes_req = '0;
    end
  end

  always_comb begin
    // A processor-strobe begin never writes; writes come from controller begins and continues.
    if ((load_ext && !cpu_hit) || cont) begin
      wr_lanes = lanes_req;
    end else begin
      wr_lanes = '0;
    end
  end

endmodule

// File: rtl/ft_sram_burst.sv
`timescale 1ns/1ps
module ft_sram_burst #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet,
  input  logic              load_ext,
  input  logic              step,
  input  logic              deselect,
  input  logic              wr_cycle,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] use_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              active_q,
  output logic              wr_q
);

  localparam int HI_W = ADDR_W - BURST_W;
  localparam logic [BURST_W-1:0] BEAT_ONE = BURST_W'(1);

  logic [ADDR_W-1:0]  next_addr;
  logic [BURST_W-1:0] beat_next;
  logic [HI_W-1:0]    upper;
  logic               addr_en;
  logic               active_d;
  logic               wr_d;

  always_comb begin
    upper     = addr_q[ADDR_W-1:BURST_W];
    beat_next = addr_q[BURST_W-1:0] + BEAT_ONE;
    next_addr = {upper, beat_next};
  end

  always_comb begin
    if (load_ext) begin
      use_addr = addr_in;
    end else if (step) begin
      use_addr = next_addr;
    end else begin
      use_addr = addr_q;
    end
  end

  always_comb begin
    addr_en = load_ext || step;
    if (quiet || deselect) begin
      active_d = 1'b0;
    end else if (load_ext) begin
      active_d = 1'b1;
    end else begin
      active_d = active_q;
    end
    wr_d = !quiet && wr_cycle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= use_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
    end
  end

  assert_begin_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ext |=> (addr_q == $past(addr_in)));

  assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_ext) |=> ((addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + BEAT_ONE)
                             && (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W]))));

  assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !quiet && !load_ext && !deselect && !step) |=> $stable(addr_q));

  assert_sleep_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !active_q);

endmodule

// File: rtl/ft_sram_array.sv
`timescale 1ns/1ps
module ft_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANE_W*LANES-1:0]   wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANE_W*LANES-1:0]   rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) begin
        mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    // Flow-through: the registered address selects the word with no output register.
    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/ft_burst_sram.sv
`timescale 1ns/1ps
module ft_burst_sram #(
  parameter int ADDR_W    = 6,
  parameter int LANE_W    = 9,
  parameter int LANES     = 2,
  parameter int BURST_W   = 2,
  parameter int SLEEP_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    step_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic                    sleep_req,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic                    rdata_drive
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              quiet;
  logic              load_ext;
  logic              step;
  logic              deselect;
  logic              proc_begin;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] use_addr;
  logic [ADDR_W-1:0] addr_q;
  logic              active_q;
  logic              wr_q;

  // Reset asserts at once and leaves through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  ft_sram_sleep #(
    .SLEEP_CYC (SLEEP_CYC),
    .WAKE_CYC  (WAKE_CYC)
  ) u_sleep (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sleep_req (sleep_req),
    .quiet     (quiet)
  );

  ft_sram_decode #(
    .LANES (LANES)
  ) u_decode (
    .quiet        (quiet),
    .active_q     (active_q),
    .en_a_n       (en_a_n),
    .en_b         (en_b),
    .en_c_n       (en_c_n),
    .strb_cpu_n   (strb_cpu_n),
    .strb_ctl_n   (strb_ctl_n),
    .step_n       (step_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .load_ext     (load_ext),
    .step         (step),
    .deselect     (deselect),
    .proc_begin   (proc_begin),
    .wr_lanes     (wr_lanes)
  );

  ft_sram_burst #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
  ) u_burst (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .quiet    (quiet),
    .load_ext (load_ext),
    .step     (step),
    .deselect (deselect),
    .wr_cycle (|wr_lanes),
    .addr_in  (addr),
    .use_addr (use_addr),
    .addr_q   (addr_q),
    .active_q (active_q),
    .wr_q     (wr_q)
  );

  ft_sram_array #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_array (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .wr_addr  (use_addr),
    .wr_data  (wdata),
    .rd_addr  (addr_q),
    .rd_data  (rdata)
  );

  // Output enable is combinational; write cycles and sleep mask it.
  assign rdata_drive = active_q && !wr_q && !out_en_n && !quiet;

  assert_cpu_reads_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    proc_begin |-> (wr_lanes == '0));

  assert_global_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_ext && !proc_begin && !wr_all_n) |-> (&wr_lanes));

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    deselect |=> !rdata_drive);

  assert_write_mask_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_q |-> !rdata_drive);

  assert_sleep_tristate_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    sleep_req |-> (!rdata_drive && (wr_lanes == '0)));

endmodule

// File: tb/test_ft_burst_sram.sv
`timescale 1ns/1ps
module test_ft_burst_sram;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_a_n, en_b, en_c_n;
  logic        strb_cpu_n, strb_ctl_n, step_n;
  logic [5:0]  addr;
  logic        wr_all_n, wr_lane_en_n;
  logic [1:0]  lane_sel_n;
  logic        out_en_n, sleep_req;
  logic [17:0] wdata;
  logic [17:0] rdata;
  logic        rdata_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic        drv;
    logic [17:0] dat;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference state
  logic [17:0] ref_mem [64];
  logic [5:0]  m_addr;
  logic        m_active;
  logic        m_wr;
  int          m_rec;

  always #5 clk = ~clk;

  ft_burst_sram i_ft_burst_sram (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_a_n       (en_a_n),
    .en_b         (en_b),
    .en_c_n       (en_c_n),
    .strb_cpu_n   (strb_cpu_n),
    .strb_ctl_n   (strb_ctl_n),
    .step_n       (step_n),
    .addr         (addr),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .out_en_n     (out_en_n),
    .sleep_req    (sleep_req),
    .wdata        (wdata),
    .rdata        (rdata),
    .rdata_drive  (rdata_drive)
  );

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle, advances the reference and queues the expectation.
  task automatic drive(input string tag,
                       input logic c_a_n, input logic c_b, input logic c_c_n,
                       input logic s_cpu_n, input logic s_ctl_n, input logic s_step_n,
                       input logic [5:0] s_addr,
                       input logic s_all_n, input logic s_len_n, input logic [1:0] s_sel_n,
                       input logic s_oe_n, input logic s_zz, input logic [17:0] s_data);
    logic       ign, en_ok, cpu, start;
    logic [1:0] req, lanes;
    exp_t       e;
    @(negedge clk);
    en_a_n = c_a_n; en_b = c_b; en_c_n = c_c_n;
    strb_cpu_n = s_cpu_n; strb_ctl_n = s_ctl_n; step_n = s_step_n;
    addr = s_addr; wr_all_n = s_all_n; wr_lane_en_n = s_len_n; lane_sel_n = s_sel_n;
    out_en_n = s_oe_n; sleep_req = s_zz; wdata = s_data;
    @(posedge clk);
    ign = s_zz || (m_rec > 0);
    if (s_zz) m_rec = 2;
    else if (m_rec > 0) m_rec = m_rec - 1;
    req   = !s_all_n ? 2'b11 : (!s_len_n ? ~s_sel_n : 2'b00);
    lanes = 2'b00;
    if (ign) begin
      m_active = 1'b0;
    end else begin
      en_ok = !c_a_n && c_b && !c_c_n;
      cpu   = !s_cpu_n && !c_a_n;
      start = cpu || !s_ctl_n;
      if (start && !en_ok) begin
        m_active = 1'b0;
      end else if (start) begin
        m_addr   = s_addr;
        m_active = 1'b1;
        lanes    = cpu ? 2'b00 : req;
      end else if (m_active) begin
        if (!s_step_n) m_addr = {m_addr[5:2], m_addr[1:0] + 2'd1};
        lanes = req;
      end
    end
    for (int l = 0; l < 2; l++) begin
      if (lanes[l]) ref_mem[m_addr][l*9 +: 9] = s_data[l*9 +: 9];
    end
    m_wr = |lanes;
    #1;
    e.drv = m_active && !m_wr && !s_oe_n && !s_zz && (m_rec == 0);
    e.dat = ref_mem[m_addr];
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic ctl_begin(input string tag, input logic [5:0] a, input logic all_n,
                           input logic len_n, input logic [1:0] sel_n, input logic [17:0] d);
    drive(tag, 0, 1, 0, 1, 0, 1, a, all_n, len_n, sel_n, 0, 0, d);
  endtask

  task automatic cpu_begin(input string tag, input logic [5:0] a, input logic all_n, input logic [17:0] d);
    drive(tag, 0, 1, 0, 0, 1, 1, a, all_n, 1, 2'b11, 0, 0, d);
  endtask

  task automatic go_on(input string tag, input logic stp_n, input logic all_n,
                       input logic len_n, input logic [1:0] sel_n, input logic oe_n, input logic [17:0] d);
    drive(tag, 0, 1, 0, 1, 1, stp_n, 6'd0, all_n, len_n, sel_n, oe_n, 0, d);
  endtask

  // Monitor: pops each expectation in the cycle after its edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " drive"}, rdata_drive === e.drv, {31'd0, rdata_drive}, {31'd0, e.drv});
        if (e.drv) check({e.tag, " data"}, rdata === e.dat, {14'd0, rdata}, {14'd0, e.dat});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_addr = '0; m_active = 1'b0; m_wr = 1'b0; m_rec = 0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    rst_n = 1'b0;
    en_a_n = 1; en_b = 1; en_c_n = 0; strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1;
    addr = '0; wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = 2'b11;
    out_en_n = 0; sleep_req = 0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    check("R4 reset state", rdata_drive === 1'b0, {31'd0, rdata_drive}, 32'd0);

    // Fill a four-beat burst from 8 with global writes (R2 write begin, R5 step, R8 mask)
    ctl_begin("R2 ctl write begin", 6'd8, 0, 1, 2'b11, 18'h2A5A5);
    go_on("R5 step write 9", 0, 0, 1, 2'b11, 0, 18'h11234);
    go_on("R5 step write 10", 0, 0, 1, 2'b11, 0, 18'h0BEEF);
    go_on("R8 write masks oe 11", 0, 0, 1, 2'b11, 0, 18'h3C0F0);
    // Wrap to 8, lane 0 only
    go_on("R3 lane0 write wrap R5", 0, 1, 0, 2'b10, 0, 18'h3FFFF);
    // Suspend on 8, lane 1 only
    go_on("R6 suspend lane1 write R3", 1, 1, 0, 2'b01, 0, 18'h00000);
    // Lane enable high: no write, read of 8
    go_on("R3 no-lane write is read", 1, 1, 1, 2'b00, 0, 18'h12345);

    // Processor begin never writes (R1)
    cpu_begin("R1 cpu begin reads", 6'd10, 0, 18'h15555);
    go_on("R7 flow read 11", 0, 1, 1, 2'b11, 0, 18'h0);
    go_on("R5 read wrap 8", 0, 1, 1, 2'b11, 0, 18'h0);
    go_on("R6 read hold 8", 1, 1, 1, 2'b11, 0, 18'h0);
    go_on("R7 oe high", 1, 1, 1, 2'b11, 1, 18'h0);
    // Output enable acts without a clock edge
    @(posedge clk);
    #4;
    out_en_n = 1'b0;
    #0.5;
    check("R7 async oe on", rdata_drive === 1'b1, {31'd0, rdata_drive}, 32'd1);
    check("R7 async data", rdata === ref_mem[8], {14'd0, rdata}, {14'd0, ref_mem[8]});
    out_en_n = 1'b1;
    #0.5;
    check("R7 async oe off", rdata_drive === 1'b0, {31'd0, rdata_drive}, 32'd0);

    // Deselect and its persistence (R4)
    drive("R4 deselect en_b low", 0, 0, 0, 1, 0, 1, 6'd9, 1, 1, 2'b11, 0, 0, 18'h0);
    go_on("R4 stays deselected", 0, 0, 1, 2'b11, 0, 18'h01111);
    cpu_begin("R1 cpu read 9", 6'd9, 1, 18'h0);
    drive("R4 cpu strobe with en_a high ignored", 1, 1, 0, 0, 1, 1, 6'd11, 0, 1, 2'b11, 0, 0, 18'h2BBBB);
    ctl_begin("R2 ctl read begin", 6'd11, 1, 1, 2'b11, 18'h0);

    // Sleep (R9) and recovery (R10)
    ctl_begin("R2 read before sleep", 6'd9, 1, 1, 2'b11, 18'h0);
    for (int k = 0; k < 4; k++) begin
      drive("R9 sleep ignores write", 0, 1, 0, 1, 0, 1, 6'd9, 0, 1, 2'b11, 0, 1, 18'h11111);
    end
    drive("R10 recovery edge 1", 0, 1, 0, 1, 0, 1, 6'd9, 0, 1, 2'b11, 0, 0, 18'h02222);
    drive("R10 recovery edge 2", 0, 1, 0, 1, 0, 1, 6'd9, 0, 1, 2'b11, 0, 0, 18'h03333);
    go_on("R9 burst ended", 0, 1, 1, 2'b11, 0, 18'h0);
    cpu_begin("R9 contents kept R10", 6'd9, 1, 18'h0);
    ctl_begin("R10 resume write", 6'd9, 0, 1, 2'b11, 18'h24444);
    cpu_begin("R10 resume readback", 6'd9, 1, 18'h0);
    cpu_begin("R3 readback 8", 6'd8, 1, 18'h0);

    @(posedge clk);
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule